// File: doc/BRIEF.md
# Byte-Lane Memory Bank Decoder

This block sits between a 32-bit system bus and a 256 KB memory region built from eight byte-wide devices of 32K x 8 each. The region starts at the aligned byte address 0x84000000 and ends at 0x8403FFFF. The devices form a grid of two banks with four byte lanes per bank. One address bit picks the bank. The four active-low byte enables pick the lanes within that bank. A device is chosen only when the upper address bits match the region's base pattern.

For each bus request the block registers four things: eight active-low chip selects, the 15-bit device-internal address taken from the bus word address, and the read and write strobes as they go to the devices. The block also holds a behavioural model of the eight devices. It merges the bytes they return into a 32-bit read word and raises a hit flag for accepted accesses inside the region. Bytes from lanes that are not driven read as zero.

Top module: `lane_bank_decode`

## Requirements
- R1: A chip select is asserted only when bus address bits 31..18 equal the base pattern 10000100000000 (binary). Addresses outside 0x84000000..0x8403FFFF assert no chip select and read as zero.
- R2: Bus address bit 17 picks the bank. Chip select index b*4+i serves bank b, lane i. With bit 17 = 0 the chip selects 0..3 may assert; with bit 17 = 1 the chip selects 4..7 may assert.
- R3: Within the chosen bank, the chip select for lane i asserts exactly when be_n[i] is 0. Lane i carries data bits 8i+7..8i.
- R4: The device address equals bus address bits 16..2. Bus bits 1..0 play no part in the mapping.
- R5: A read needs rd_n = 0 and oe_n = 0. Its data appears on rdata one cycle after the request, with the bytes of the enabled lanes in place and all other bytes zero. When rd_n or oe_n was high, rdata is zero.
- R6: A write stores the bytes of the enabled lanes into the chosen bank. All other lanes, the other bank and every access outside the region leave the stored bytes unchanged.
- R7: One cycle after a request, hit is 1 when the address was in the region, at least one byte enable was low, and exactly one of rd_n and wr_n was low. Otherwise hit is 0.
- R8: The device strobes dev_rd_n and dev_wr_n follow rd_n and wr_n with one cycle of delay. If rd_n and wr_n are both low, both device strobes stay high and neither a read nor a write takes place.
- R9: While rst is high at a clock edge, the outputs after that edge are: all chip selects high, both device strobes high, hit 0, dev_addr 0 and rdata 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 32 | Bus byte address |
| be_n | input | 4 | Byte-lane enables, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | 32 | Write data |
| cs_n | output | 8 | Chip selects, active low, index bank*4+lane |
| dev_addr | output | 15 | Device-internal address |
| dev_rd_n | output | 1 | Read strobe to devices, active low |
| dev_wr_n | output | 1 | Write strobe to devices, active low |
| rdata | output | 32 | Merged read data |
| hit | output | 1 | Accepted access inside the region |

## Verification
Every result is due exactly one clock edge after its request is sampled. This covers the chip selects, the device address, the device strobes, hit and rdata. A write takes effect at that same edge, so a read issued in the next cycle returns the new bytes. Each bench task drives its inputs on a falling edge, waits for one rising edge, and samples 1 ns later, well before the next falling edge changes the inputs. No check therefore falls on the active edge. The checker relates each registered output to the inputs one cycle earlier through `$past`, which matches the same single-cycle latency.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int unsigned BUS_AW     = 32;
  localparam int unsigned LANE_CNT   = 4;
  localparam int unsigned BANK_CNT   = 2;
  localparam int unsigned DEV_AW     = 15;
  localparam int unsigned MODEL_AW   = 8;
  localparam logic [31:0] REGION_BASE = 32'h8400_0000;
endpackage

// File: rtl/lane_decode.sv
module lane_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned BANKS  = 2,
  parameter int unsigned DEV_AW = 15,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [LANES-1:0]       be_n,
  input  logic                   rd_n,
  input  logic                   wr_n,
  output logic                   in_region,
  output logic [BANKS*LANES-1:0] cs,
  output logic [DEV_AW-1:0]      dev_addr,
  output logic                   rd_go,
  output logic                   wr_go
);
  localparam int unsigned LSB      = $clog2(LANES);
  localparam int unsigned BSEL_W   = $clog2(BANKS);
  localparam int unsigned BANK_LSB = LSB + DEV_AW;
  localparam int unsigned MATCH_LO = BANK_LSB + BSEL_W;

  logic [BSEL_W-1:0] bank_idx;
  logic              unused_low;

  assign unused_low = ^addr[LSB-1:0];
  assign in_region  = (addr[ADDR_W-1:MATCH_LO] == BASE[ADDR_W-1:MATCH_LO]);
  assign bank_idx   = addr[BANK_LSB +: BSEL_W];
  assign dev_addr   = addr[LSB +: DEV_AW];
  assign rd_go      = !rd_n && wr_n;
  assign wr_go      = !wr_n && rd_n;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign cs[b*LANES+l] = in_region && (bank_idx == BSEL_W'(b)) && !be_n[l];
    end
  end
endmodule

// File: rtl/lane_device.sv
module lane_device #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/lane_merge.sv
module lane_merge #(
  parameter int unsigned LANES = 4,
  parameter int unsigned BANKS = 2
) (
  input  logic [BANKS*LANES*8-1:0] q_all,
  input  logic [BANKS*LANES-1:0]   drv,
  output logic [LANES*8-1:0]       rdata
);
  always_comb begin
    rdata = '0;
    for (int b = 0; b < BANKS; b++) begin
      for (int l = 0; l < LANES; l++) begin
        if (drv[b*LANES+l])
          rdata[8*l +: 8] = rdata[8*l +: 8] | q_all[(b*LANES+l)*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/lane_bank_decode.sv
module lane_bank_decode #(
  parameter int unsigned ADDR_W   = lane_pkg::BUS_AW,
  parameter int unsigned LANES    = lane_pkg::LANE_CNT,
  parameter int unsigned BANKS    = lane_pkg::BANK_CNT,
  parameter int unsigned DEV_AW   = lane_pkg::DEV_AW,
  parameter int unsigned MODEL_AW = lane_pkg::MODEL_AW,
  parameter logic [ADDR_W-1:0] BASE = lane_pkg::REGION_BASE
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [LANES-1:0]       be_n,
  input  logic                   rd_n,
  input  logic                   wr_n,
  input  logic                   oe_n,
  input  logic [LANES*8-1:0]     wdata,
  output logic [BANKS*LANES-1:0] cs_n,
  output logic [DEV_AW-1:0]      dev_addr,
  output logic                   dev_rd_n,
  output logic                   dev_wr_n,
  output logic [LANES*8-1:0]     rdata,
  output logic                   hit
);
  localparam int unsigned NDEV = BANKS * LANES;

  logic              in_region;
  logic [NDEV-1:0]   cs_c;
  logic [DEV_AW-1:0] dev_addr_c;
  logic              rd_go;
  logic              wr_go;
  logic              read_en;
  logic [NDEV-1:0]   drv_q;
  logic [NDEV*8-1:0] q_all;

  lane_decode #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BANKS(BANKS), .DEV_AW(DEV_AW), .BASE(BASE)
  ) u_dec (
    .addr(bus_addr), .be_n(be_n), .rd_n(rd_n), .wr_n(wr_n),
    .in_region(in_region), .cs(cs_c), .dev_addr(dev_addr_c),
    .rd_go(rd_go), .wr_go(wr_go)
  );

  assign read_en = rd_go && !oe_n;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int unsigned K = b*LANES + l;
      lane_device #(.AW(MODEL_AW), .DW(8)) u_dev (
        .clk(clk),
        .we(cs_c[K] && wr_go),
        .re(cs_c[K] && read_en),
        .addr(dev_addr_c[MODEL_AW-1:0]),
        .wdata(wdata[8*l +: 8]),
        .q(q_all[K*8 +: 8])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n     <= '1;
      dev_addr <= '0;
      dev_rd_n <= 1'b1;
      dev_wr_n <= 1'b1;
      hit      <= 1'b0;
      drv_q    <= '0;
    end else begin
      cs_n     <= ~cs_c;
      dev_addr <= dev_addr_c;
      dev_rd_n <= !rd_go;
      dev_wr_n <= !wr_go;
      hit      <= in_region && !(&be_n) && (rd_go || wr_go);
      drv_q    <= cs_c & {NDEV{read_en}};
    end
  end

  lane_merge #(.LANES(LANES), .BANKS(BANKS)) u_merge (
    .q_all(q_all), .drv(drv_q), .rdata(rdata)
  );
endmodule

// File: rtl/lane_bank_decode_chk.sv
module lane_bank_decode_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned BANKS  = 2,
  parameter int unsigned DEV_AW = 15,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [LANES-1:0]       be_n,
  input logic                   rd_n,
  input logic                   wr_n,
  input logic                   oe_n,
  input logic [BANKS*LANES-1:0] cs_n,
  input logic [DEV_AW-1:0]      dev_addr,
  input logic                   dev_rd_n,
  input logic                   dev_wr_n,
  input logic [LANES*8-1:0]     rdata,
  input logic                   hit
);
  localparam int unsigned LSB      = $clog2(LANES);
  localparam int unsigned BSEL_W   = $clog2(BANKS);
  localparam int unsigned BANK_LSB = LSB + DEV_AW;
  localparam int unsigned MATCH_LO = BANK_LSB + BSEL_W;

  logic unused_chk;
  assign unused_chk = ^bus_addr[LSB-1:0];

  AST_CS_IN_REGION: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (cs_n != '1)) |->
      ($past(bus_addr[ADDR_W-1:MATCH_LO]) == BASE[ADDR_W-1:MATCH_LO])); // R1

  for (genvar b = 0; b < BANKS; b++) begin : g_b
    for (genvar l = 0; l < LANES; l++) begin : g_l
      AST_BANK_SEL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !cs_n[b*LANES+l]) |->
          ($past(bus_addr[BANK_LSB +: BSEL_W]) == BSEL_W'(b))); // R2
      AST_LANE_EN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !cs_n[b*LANES+l]) |-> !$past(be_n[l])); // R3
    end
  end

  AST_DEV_ADDR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (dev_addr == $past(bus_addr[LSB +: DEV_AW]))); // R4

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_n || oe_n)) |-> (rdata == '0)); // R5

  AST_HIT_REGION: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hit) |->
      (($past(bus_addr[ADDR_W-1:MATCH_LO]) == BASE[ADDR_W-1:MATCH_LO]) && !$past(&be_n))); // R7

  AST_STROBE_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!rd_n && !wr_n)) |-> (dev_rd_n && dev_wr_n && !hit)); // R8

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> ((cs_n == '1) && dev_rd_n && dev_wr_n && !hit && (rdata == '0))); // R9
endmodule

bind lane_bank_decode lane_bank_decode_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .BANKS(BANKS), .DEV_AW(DEV_AW), .BASE(BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .be_n(be_n), .rd_n(rd_n),
  .wr_n(wr_n), .oe_n(oe_n), .cs_n(cs_n), .dev_addr(dev_addr),
  .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .rdata(rdata), .hit(hit)
);

// File: tb/sim_lane_bank_decode.sv
`timescale 1ns/1ps
module sim_lane_bank_decode;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic [3:0]  be_n = 4'hF;
  logic        rd_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
  logic [31:0] wdata = '0;
  logic [7:0]  cs_n;
  logic [14:0] dev_addr;
  logic        dev_rd_n, dev_wr_n, hit;
  logic [31:0] rdata;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lane_bank_decode u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .be_n(be_n), .rd_n(rd_n),
    .wr_n(wr_n), .oe_n(oe_n), .wdata(wdata), .cs_n(cs_n), .dev_addr(dev_addr),
    .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .rdata(rdata), .hit(hit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the next rising edge
  task automatic cyc(input logic [31:0] a, input logic [3:0] be, input logic r,
                     input logic w, input logic o, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; be_n = be; rd_n = r; wr_n = w; oe_n = o; wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
    cyc(a, be, 1'b1, 1'b0, 1'b1, d);
  endtask

  task automatic rd(input logic [31:0] a, input logic [3:0] be);
    cyc(a, be, 1'b0, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic t_reset();
    chk("R9 cs_n", {24'h0, cs_n}, 32'hFF);
    chk("R9 hit", {31'h0, hit}, 32'h0);
    chk("R9 rdata", rdata, 32'h0);
    chk("R9 strobes", {30'h0, dev_rd_n, dev_wr_n}, 32'h3);
    chk("R9 dev_addr", {17'h0, dev_addr}, 32'h0);
  endtask

  task automatic t_word_banks();
    wr(32'h8400_0010, 4'h0, 32'hDEAD_BEEF);
    chk("R2 bank0 cs_n", {24'h0, cs_n}, 32'hF0);
    chk("R4 dev_addr", {17'h0, dev_addr}, 32'h4);
    chk("R8 write strobes", {30'h0, dev_rd_n, dev_wr_n}, 32'h2);
    chk("R7 hit write", {31'h0, hit}, 32'h1);
    rd(32'h8400_0010, 4'h0);
    chk("R5 word read", rdata, 32'hDEAD_BEEF);
    chk("R8 read strobes", {30'h0, dev_rd_n, dev_wr_n}, 32'h1);
    wr(32'h8402_0010, 4'h0, 32'h1122_3344);
    chk("R2 bank1 cs_n", {24'h0, cs_n}, 32'h0F);
    rd(32'h8402_0010, 4'h0);
    chk("R2 bank1 read", rdata, 32'h1122_3344);
    rd(32'h8400_0010, 4'h0);
    chk("R6 bank0 untouched", rdata, 32'hDEAD_BEEF);
  endtask

  task automatic t_partial();
    wr(32'h8400_0010, 4'b1100, 32'hFFFF_5678);
    chk("R3 half cs_n", {24'h0, cs_n}, 32'hFC);
    rd(32'h8400_0010, 4'h0);
    chk("R6 low half write", rdata, 32'hDEAD_5678);
    wr(32'h8400_0010, 4'b1011, 32'h00AB_0000);
    chk("R3 lane2 cs_n", {24'h0, cs_n}, 32'hFB);
    rd(32'h8400_0010, 4'h0);
    chk("R6 byte write", rdata, 32'hDEAB_5678);
    rd(32'h8400_0010, 4'b1100);
    chk("R5 low half read", rdata, 32'h0000_5678);
    rd(32'h8400_0013, 4'b0111);
    chk("R5 lane3 read", rdata, 32'hDE00_0000);
    chk("R4 low bits ignored", {17'h0, dev_addr}, 32'h4);
  endtask

  task automatic t_outside();
    rd(32'h8500_0010, 4'h0);
    chk("R1 outside cs_n", {24'h0, cs_n}, 32'hFF);
    chk("R7 outside hit", {31'h0, hit}, 32'h0);
    chk("R1 outside rdata", rdata, 32'h0);
    wr(32'h0400_0010, 4'h0, 32'h0);
    chk("R1 bit31 differs cs_n", {24'h0, cs_n}, 32'hFF);
    rd(32'h8400_0010, 4'h0);
    chk("R6 outside write ignored", rdata, 32'hDEAB_5678);
    rd(32'h8404_0000, 4'h0);
    chk("R1 above end", {23'h0, hit, cs_n}, 32'hFF);
    rd(32'h83FF_FFFC, 4'h0);
    chk("R1 below base", {23'h0, hit, cs_n}, 32'hFF);
  endtask

  task automatic t_boundary();
    wr(32'h8403_FFFC, 4'h0, 32'hCAFE_F00D);
    chk("R4 top dev_addr", {17'h0, dev_addr}, 32'h7FFF);
    chk("R2 top cs_n", {24'h0, cs_n}, 32'h0F);
    rd(32'h8403_FFFC, 4'h0);
    chk("R5 top read", rdata, 32'hCAFE_F00D);
    wr(32'h8401_FFFC, 4'hF, 32'h0);
    chk("R7 no lanes hit", {31'h0, hit}, 32'h0);
    chk("R3 no lanes cs_n", {24'h0, cs_n}, 32'hFF);
    chk("R4 bank0 top dev_addr", {17'h0, dev_addr}, 32'h7FFF);
    cyc(32'h8400_0010, 4'h0, 1'b1, 1'b1, 1'b1, 32'h0);
    chk("R7 idle hit", {31'h0, hit}, 32'h0);
    chk("R3 idle cs_n", {24'h0, cs_n}, 32'hF0);
  endtask

  task automatic t_oe_conflict();
    cyc(32'h8400_0010, 4'h0, 1'b0, 1'b1, 1'b1, 32'h0);
    chk("R5 oe high rdata", rdata, 32'h0);
    chk("R8 oe high rd strobe", {31'h0, dev_rd_n}, 32'h0);
    cyc(32'h8400_0010, 4'h0, 1'b0, 1'b0, 1'b0, 32'h5555_5555);
    chk("R8 conflict strobes", {30'h0, dev_rd_n, dev_wr_n}, 32'h3);
    chk("R8 conflict hit", {31'h0, hit}, 32'h0);
    chk("R8 conflict rdata", rdata, 32'h0);
    rd(32'h8400_0010, 4'h0);
    chk("R8 conflict no write", rdata, 32'hDEAB_5678);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_word_banks();
    t_partial();
    t_outside();
    t_boundary();
    t_oe_conflict();
    cyc(32'h0, 4'hF, 1'b1, 1'b1, 1'b1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule